// File: doc/BRIEF.md
# Receive Descriptor-Chain DMA Engine

This block moves received bytes from a serial receive stream into host memory, guided by a linked list of descriptors that the host prepares in advance. Each descriptor names a data buffer and its size, points to the next descriptor, and carries a stop flag. The engine reads a descriptor, packs incoming bytes into 32-bit words at the buffer's address, and writes a completion status word back into the descriptor. When the buffer fills or the frame ends, it follows the next pointer. A descriptor with a byte count of zero is completed at once with no data transfer.

A descriptor with its stop flag set is a fault once its buffer is full. The engine writes that descriptor's status, raises an error interrupt, and then refuses to follow the chain. While it is stopped, it keeps accepting bytes from the stream and throws them away. It counts these dropped bytes in a saturating counter. It stays in that state until the host issues an initialize command with a fresh base descriptor address.

The byte stream is valid/ready. A byte moves on every clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low whenever the engine is busy with a memory transaction or a descriptor fetch, or is idle after reset. The sender must then hold its byte, data and last flag stable. The memory port carries one transaction at a time. It holds a request until it sees a single-cycle acknowledge.

Top module: `rxdesc_dma`

## Requirements
- R1: A descriptor is four 32-bit words at a word-aligned pointer P. The engine reads P (bit 31 = stop flag, bits 15:0 = buffer byte count), then P+4 (buffer byte address), then P+8 (next-descriptor pointer), in that order.
- R2: Received bytes are stored little-endian. The byte at buffer offset k goes to lane (buffer address + k) bits 1:0 of the word at that address with bits 1:0 cleared. The enable of each lane written is set. A word is written when lane 3 is filled, when the byte carries the last flag, or when the buffer becomes full.
- R3: On completion, the engine writes the status word to P+12: bit 31 = frame ended in this buffer, bit 30 = stop-flag fault, bits 15:0 = bytes stored, other bits 0. With no fault, it then fetches the descriptor at the next pointer. A buffer that fills without the last flag continues the frame in the next descriptor.
- R4: `irq_frame` pulses for one cycle after the status write of a descriptor that ended a frame without a fault.
- R5: A descriptor with byte count 0 and stop flag clear is completed with status 0 and no data writes.
- R6: When a descriptor with the stop flag set becomes full, the next pointer is not followed. No memory request is made until re-initialization.
- R7: While stopped, `in_ready` is high, every byte offered is discarded with no memory write, and `overflow` is high.
- R8: `irq_err` pulses for one cycle, in the cycle after the acknowledge of the faulting descriptor's status write.
- R9: `drop_cnt` counts the bytes discarded while stopped and saturates at 0xFFFF.
- R10: After reset the engine is idle, with `in_ready`, `mem_req`, the interrupts and `overflow` all low. `cmd_init` is honoured only when idle or stopped. It loads `base_addr` as the descriptor pointer, clears `overflow` and `drop_cnt`, and starts a fetch. Otherwise a stopped engine stays stopped.
- R11: `mem_req` stays high with a stable address until `mem_ack`.
- R12: `in_ready` is low while a descriptor fetch or a memory write is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_init | input | 1 | Initialize command pulse |
| base_addr | input | ADDR_W | First descriptor pointer loaded on initialize |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | One-cycle transaction acknowledge |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Byte ends the frame |
| in_ready | output | 1 | Engine accepts a byte |
| irq_frame | output | 1 | Frame-complete interrupt pulse |
| irq_err | output | 1 | Stop-flag fault interrupt pulse |
| overflow | output | 1 | Engine stopped and discarding |
| drop_cnt | output | DROP_W | Saturating count of discarded bytes |

## Verification
On every cycle, the assertions check four things. A memory request holds its address until acknowledged. A stopped engine issues no memory request and stays stopped unless initialized. The fault interrupt directly follows an acknowledged write. The drop counter never decreases between initializations. The bench's scenarios are needed for the rest: byte-lane packing and enables, the status word contents, a frame spanning descriptors, the zero-length skip, the exact fetch count before a stop, and counter saturation. These require a memory model and known descriptor chains.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_CTL,
    S_RD_BUF,
    S_RD_NXT,
    S_RECV,
    S_WR_DATA,
    S_WR_STAT,
    S_HALT
  } rxd_state_t;

  localparam int unsigned CTL_STOP_BIT = 31;
  localparam int unsigned STAT_EOF_BIT = 31;
  localparam int unsigned STAT_ERR_BIT = 30;
  localparam int unsigned LEN_W        = 16;
  localparam int unsigned OFS_BUF      = 4;
  localparam int unsigned OFS_NXT      = 8;
  localparam int unsigned OFS_STAT     = 12;
endpackage

// File: rtl/rxd_lane_pack.sv
module rxd_lane_pack #(
  parameter int unsigned LANES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [$clog2(LANES)-1:0]   lane,
  input  logic [7:0]                 din,
  output logic [LANES*8-1:0]         word,
  output logic [LANES-1:0]           be
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        be[g]          <= 1'b0;
        word[g*8 +: 8] <= 8'h00;
      end else if (clr) begin
        be[g]          <= 1'b0;
        word[g*8 +: 8] <= 8'h00;
      end else if (push && (lane == g)) begin
        be[g]          <= 1'b1;
        word[g*8 +: 8] <= din;
      end
    end
  end
endmodule

// File: rtl/rxd_sat_cnt.sv
module rxd_sat_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  AST_DROP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt >= $past(cnt)); // R9
endmodule

// File: rtl/rxdesc_dma.sv
module rxdesc_dma
  import rxd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_init,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              irq_frame,
  output logic              irq_err,
  output logic              overflow,
  output logic [DROP_W-1:0] drop_cnt
);
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = $clog2(LANES);

  rxd_state_t        st;
  logic [ADDR_W-1:0] desc_ptr, next_ptr, buf_addr, word_addr, cur_addr;
  logic [LEN_W-1:0]  limit, filled, filled_nx;
  logic              stop_f, eof_f, full_f;
  logic              take, init_ok, fault, buf_done;
  logic [31:0]       pk_word, status_w;
  logic [3:0]        pk_be;

  assign init_ok   = cmd_init && (st == S_IDLE || st == S_HALT);
  assign in_ready  = (st == S_RECV) || (st == S_HALT);
  assign overflow  = (st == S_HALT);
  assign take      = in_valid && (st == S_RECV);
  assign cur_addr  = buf_addr + ADDR_W'(filled);
  assign filled_nx = filled + 1'b1;
  assign buf_done  = (filled_nx == limit);
  assign fault     = stop_f && full_f;

  always_comb begin
    status_w = '0;
    status_w[STAT_EOF_BIT] = eof_f;
    status_w[STAT_ERR_BIT] = fault;
    status_w[LEN_W-1:0]    = filled;
  end

  rxd_lane_pack #(.LANES(LANES)) u_pack (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (st == S_WR_DATA && mem_ack),
    .push (take),
    .lane (cur_addr[LANE_W-1:0]),
    .din  (in_data),
    .word (pk_word),
    .be   (pk_be)
  );

  rxd_sat_cnt #(.W(DROP_W)) u_drop (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (init_ok),
    .inc  (in_valid && st == S_HALT),
    .cnt  (drop_cnt)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_ptr;
    mem_wdata = '0;
    mem_be    = 4'hF;
    unique case (st)
      S_RD_CTL:  mem_req = 1'b1;
      S_RD_BUF:  begin mem_req = 1'b1; mem_addr = desc_ptr + ADDR_W'(OFS_BUF); end
      S_RD_NXT:  begin mem_req = 1'b1; mem_addr = desc_ptr + ADDR_W'(OFS_NXT); end
      S_WR_DATA: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = word_addr;
        mem_wdata = pk_word; mem_be = pk_be;
      end
      S_WR_STAT: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = desc_ptr + ADDR_W'(OFS_STAT); mem_wdata = status_w;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      desc_ptr  <= '0;
      next_ptr  <= '0;
      buf_addr  <= '0;
      word_addr <= '0;
      limit     <= '0;
      filled    <= '0;
      stop_f    <= 1'b0;
      eof_f     <= 1'b0;
      full_f    <= 1'b0;
      irq_frame <= 1'b0;
      irq_err   <= 1'b0;
    end else begin
      irq_frame <= 1'b0;
      irq_err   <= 1'b0;
      unique case (st)
        S_IDLE, S_HALT: if (init_ok) begin
          desc_ptr <= base_addr;
          st       <= S_RD_CTL;
        end
        S_RD_CTL: if (mem_ack) begin
          stop_f <= mem_rdata[CTL_STOP_BIT];
          limit  <= mem_rdata[LEN_W-1:0];
          filled <= '0;
          eof_f  <= 1'b0;
          full_f <= 1'b0;
          st     <= S_RD_BUF;
        end
        S_RD_BUF: if (mem_ack) begin
          buf_addr <= mem_rdata[ADDR_W-1:0];
          st       <= S_RD_NXT;
        end
        S_RD_NXT: if (mem_ack) begin
          next_ptr <= mem_rdata[ADDR_W-1:0];
          if (limit == '0) begin
            full_f <= 1'b1;
            st     <= S_WR_STAT;
          end else begin
            st <= S_RECV;
          end
        end
        S_RECV: if (take) begin
          filled    <= filled_nx;
          word_addr <= {cur_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
          if (&cur_addr[LANE_W-1:0] || in_last || buf_done) begin
            eof_f  <= in_last;
            full_f <= buf_done;
            st     <= S_WR_DATA;
          end
        end
        S_WR_DATA: if (mem_ack) begin
          st <= (eof_f || full_f) ? S_WR_STAT : S_RECV;
        end
        S_WR_STAT: if (mem_ack) begin
          if (fault) begin
            irq_err <= 1'b1;
            st      <= S_HALT;
          end else begin
            irq_frame <= eof_f;
            desc_ptr  <= next_ptr;
            st        <= S_RD_CTL;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R11

  AST_HALT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !mem_req); // R6

  AST_HALT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !cmd_init) |=> overflow); // R10

  AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> $past(mem_req && mem_we && mem_ack)); // R8

  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_err && irq_frame)); // R4
endmodule

// File: tb/rxdesc_dma_tb.sv
module rxdesc_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_init = 1'b0;
  logic [31:0] base_addr = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0]  mem_be;
  logic        in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0]  in_data = '0;
  logic        irq_frame, irq_err, overflow;
  logic [15:0] drop_cnt;

  int checks = 0, fails = 0;
  int rd_cnt = 0, frame_irqs = 0, err_irqs = 0;
  logic [31:0] last_wr_addr = '0;
  logic [67:0] exp_q[$];
  logic [31:0] mem [0:255];
  bit done = 0;

  always #10 clk = ~clk;

  rxdesc_dma u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_init(cmd_init), .base_addr(base_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .irq_frame(irq_frame),
    .irq_err(irq_err), .overflow(overflow), .drop_cnt(drop_cnt)
  );

  // memory model: one-cycle acknowledge, registered read data
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst_n && mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[9:2]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares every acknowledged write with the scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (!mem_we) rd_cnt++;
      else begin
        last_wr_addr = mem_addr;
        if (exp_q.size() == 0) chk(0, "R2/R3 unexpected write", mem_addr, 32'hx);
        else begin
          logic [67:0] e;
          e = exp_q.pop_front();
          chk({mem_addr, mem_wdata, mem_be} == e, "R2/R3 write addr/data/be",
              mem_wdata, e[35:4]);
          chk(mem_addr == e[67:36], "R2/R3 write address", mem_addr, e[67:36]);
        end
      end
    end
    if (rst_n && irq_frame) frame_irqs++;
    if (rst_n && irq_err) begin
      err_irqs++;
      chk(last_wr_addr[3:0] == 4'hC, "R8 irq_err follows status write", last_wr_addr, 32'hC);
    end
  end

  task automatic expect_wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    exp_q.push_back({a, d, be});
  endtask

  task automatic send_byte(input logic [7:0] d, input bit last);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic init_at(input logic [31:0] a);
    @(negedge clk);
    base_addr = a; cmd_init = 1'b1;
    @(negedge clk);
    cmd_init = 1'b0;
    chk(in_ready == 1'b0, "R12 in_ready low during fetch", {31'b0, in_ready}, 32'h0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_desc(input int p, input bit stop, input int cnt, input int ba, input int nx);
    mem[p/4]     = {stop, 15'b0, 16'(cnt)};
    mem[p/4 + 1] = ba;
    mem[p/4 + 2] = nx;
    mem[p/4 + 3] = 32'hDEAD_BEEF;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    put_desc(32'h000, 0, 6, 32'h100, 32'h010);
    put_desc(32'h010, 0, 8, 32'h140, 32'h020);
    put_desc(32'h020, 0, 0, 32'h000, 32'h030);
    put_desc(32'h030, 0, 4, 32'h180, 32'h050);
    put_desc(32'h050, 1, 5, 32'h1A0, 32'h000);
    put_desc(32'h060, 0, 3, 32'h1C2, 32'h070);
    put_desc(32'h070, 1, 1, 32'h1E0, 32'h000);

    repeat (3) @(negedge clk);
    chk(!in_ready && !mem_req && !irq_frame && !irq_err && !overflow && drop_cnt == 0,
        "R10 reset state", {in_ready, mem_req, irq_frame, irq_err, overflow}, 32'h0);
    rst_n = 1'b1;
    idle(3);
    chk(mem_req == 1'b0, "R10 idle without init", {31'b0, mem_req}, 32'h0);

    // frame 1: fills descriptor at 0x000 exactly, with end of frame
    expect_wr(32'h100, 32'h04030201, 4'hF);
    expect_wr(32'h104, 32'h00000605, 4'h3);
    expect_wr(32'h00C, 32'h80000006, 4'hF);
    init_at(32'h000);
    for (int i = 1; i <= 6; i++) send_byte(8'(i), i == 6);
    idle(12);
    chk(frame_irqs == 1, "R4 frame interrupt", frame_irqs, 1);

    // frame 2: spans 0x010 (full, no end), skips empty 0x020, ends in 0x030
    expect_wr(32'h140, 32'h14131211, 4'hF);
    expect_wr(32'h144, 32'h18171615, 4'hF);
    expect_wr(32'h01C, 32'h00000008, 4'hF);
    expect_wr(32'h02C, 32'h00000000, 4'hF); // R5 empty descriptor, no data
    expect_wr(32'h180, 32'h00001A19, 4'h3);
    expect_wr(32'h03C, 32'h80000002, 4'hF);
    for (int i = 1; i <= 10; i++) send_byte(8'(8'h10 + i), i == 10);
    idle(12);
    chk(frame_irqs == 2, "R3 frame across descriptors single interrupt", frame_irqs, 2);
    chk(mem[32'h02C/4] == 32'h0, "R5 empty descriptor status", mem[32'h02C/4], 32'h0);

    // frame 3: stop-flag descriptor at 0x050 fills after 5 bytes, 2 more dropped
    expect_wr(32'h1A0, 32'h24232221, 4'hF);
    expect_wr(32'h1A4, 32'h00000025, 4'h1);
    expect_wr(32'h05C, 32'h40000005, 4'hF);
    for (int i = 1; i <= 7; i++) send_byte(8'(8'h20 + i), i == 7);
    idle(4);
    chk(err_irqs == 1, "R8 error interrupt once", err_irqs, 1);
    chk(frame_irqs == 2, "R4 no frame interrupt on fault", frame_irqs, 2);
    chk(overflow == 1'b1, "R7 overflow while stopped", {31'b0, overflow}, 1);
    chk(drop_cnt == 16'd2, "R9 dropped bytes", drop_cnt, 2);
    chk(rd_cnt == 15, "R1 descriptor reads before stop", rd_cnt, 15);
    for (int i = 0; i < 3; i++) send_byte(8'hEE, i == 2);
    idle(20);
    chk(drop_cnt == 16'd5, "R7 R9 more bytes discarded", drop_cnt, 5);
    chk(rd_cnt == 15, "R6 next pointer not followed", rd_cnt, 15);
    chk(exp_q.size() == 0, "R7 no writes while stopped", exp_q.size(), 0);
    chk(in_ready == 1'b1, "R7 in_ready high while stopped", {31'b0, in_ready}, 1);

    // re-initialize: unaligned buffer then second stop-flag fault
    expect_wr(32'h1C0, 32'h32310000, 4'hC);
    expect_wr(32'h06C, 32'h80000002, 4'hF);
    init_at(32'h060);
    chk(drop_cnt == 0 && overflow == 0, "R10 init clears overflow and count",
        {15'b0, overflow, drop_cnt}, 32'h0);
    send_byte(8'h31, 0);
    send_byte(8'h32, 1);
    idle(12);
    chk(frame_irqs == 3, "R4 frame interrupt after restart", frame_irqs, 3);
    expect_wr(32'h1E0, 32'h00000041, 4'h1);
    expect_wr(32'h07C, 32'h40000001, 4'hF);
    send_byte(8'h41, 0);
    idle(12);
    chk(err_irqs == 2, "R8 second fault interrupt", err_irqs, 2);
    for (int i = 0; i < 65540; i++) send_byte(8'h55, 0);
    idle(3);
    chk(drop_cnt == 16'hFFFF, "R9 saturation", drop_cnt, 32'hFFFF);
    chk(exp_q.size() == 0, "R2 all expected writes seen", exp_q.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule